// File: doc/BRIEF.md
# Configuration Access Router

This block accepts one configuration request at a time, given as a bus number, device number, function number, register offset, a read/write flag and write data. It decides where the request may go and how. A request aimed at the root bus goes to the controller's own register space. A request aimed at the bus directly below the root goes through a type-0 configuration window. A request aimed at any other bus goes through a type-1 configuration window. The root bus is the bus whose number equals the `firstBus` input. Device numbers other than zero are refused. Function numbers other than zero are refused on the root bus only.

Before a remote access, the block makes two register writes toward the address translator. These retarget translation region 0 (for type-0) or region 1 (for type-1) to the requested bus, device and function. Only after both writes complete does the window access go out. The request, translator-register, window and response ports each use a valid/ready handshake. Every accepted request produces exactly one response, which carries read data and an error flag. Byte and word merging belong to the caller; window offsets are always whole dwords.

Top module: `cfg_router`

## Requirements
- R1: A request whose device number is nonzero is rejected. No translator write and no window access follow. The response has error = 1, and for a read its data is 0xFFFFFFFF.
- R2: A request on the root bus (reqBus == firstBus) with a nonzero function number is rejected as in R1. A nonzero function number on any other bus is accepted.
- R3: A rejected write is dropped with no translator write and no window access. Its response has error = 1 and data 0.
- R4: A valid request on the root bus makes exactly one window access with winSel = 0 (local registers) and no translator write. On every window access, winOffset equals the request offset with bits 1:0 cleared.
- R5: A valid request with reqBus == firstBus + 1 (modulo 256, so firstBus 0xFF pairs with bus 0x00) produces two translator writes and then a window access with winSel = 1 (type-0). The first write is data 0x00000000 to address 0x900, which selects outbound region 0 (bit 31 = 0 outbound, low bits = region index). The second write goes to address 0x918 with data bus in bits 31:24, device in bits 23:19, function in bits 18:16 and zeros elsewhere.
- R6: A valid request on any other bus, including buses below firstBus, produces the same pair of writes with region index 1 (first write data 0x00000001). The window access then has winSel = 2 (type-1).
- R7: For remote requests, winValid does not rise until both translator writes have completed their handshakes.
- R8: While regValid or winValid is high and the matching ready is low, the valid stays high and the address, data, select and offset stay unchanged.
- R9: reqReady is high only when the block is idle. Each accepted request gives exactly one response, held stable until rspReady. A valid read returns the window data and a valid write returns data 0, both with error = 0. Window write data equals the request write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| firstBus | input | 8 | Bus number of the root bus |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted (idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqDev | input | 5 | Target device number |
| reqFunc | input | 3 | Target function number |
| reqOffset | input | 12 | Register byte offset |
| reqWdata | input | 32 | Write data |
| regValid | output | 1 | Translator register write valid |
| regReady | input | 1 | Translator register write ready |
| regAddr | output | 12 | Translator register address |
| regData | output | 32 | Translator register write data |
| winValid | output | 1 | Window access valid |
| winReady | input | 1 | Window access complete |
| winSel | output | 2 | 0 local, 1 type-0, 2 type-1 |
| winWrite | output | 1 | Window access is a write |
| winOffset | output | 12 | Dword-aligned offset |
| winWdata | output | 32 | Window write data |
| winRdata | input | 32 | Window read data, valid with winReady |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response taken |
| rspError | output | 1 | Request was rejected |
| rspRdata | output | 32 | Read data (0 for writes) |

## Verification
The bench builds the block with its defaults: 8-bit bus, 5-bit device, 3-bit function and 12-bit offset fields. The 8-bit bus field makes the wrap from firstBus 0xFF to bus 0x00 cheap to hit directly, and random requests centred on firstBus land in the root, the next bus, buses above it and buses below it in roughly equal measure. The bench also drops its ready inputs at random, so the translator and window ports stall often. That exercises the holding rule and the ordering of retarget writes before the window access.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  // Route codes double as window select codes for the three valid routes.
  typedef enum logic [1:0] {
    RT_LOCAL = 2'd0,
    RT_TYPE0 = 2'd1,
    RT_TYPE1 = 2'd2,
    RT_BAD   = 2'd3
  } route_e;

  // Bit positions of the retarget word, fixed by the translator's decode.
  localparam int BUS_LSB = 24;
  localparam int DEV_LSB = 19;
  localparam int FN_LSB  = 16;

  typedef struct packed {
    logic load;       // latch the incoming request
    logic selTarget;  // 0: viewport write, 1: target write
    logic capture;    // latch window result into the response
    logic reject;     // latch an error response
  } ctrlStrobe_t;

endpackage

// File: rtl/cfg_router_dp.sv
module cfg_router_dp
  import cfg_router_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] VIEWPORT_ADDR = 12'h900,
  parameter logic [REG_AW-1:0] TARGET_ADDR   = 12'h918
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BUS_W-1:0]  firstBus,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FN_W-1:0]   reqFunc,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] winRdata,
  output route_e            inRoute,
  output route_e            routeQ,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic [1:0]        winSel,
  output logic              winWrite,
  output logic [OFF_W-1:0]  winOffset,
  output logic [DATA_W-1:0] winWdata,
  output logic              rspError,
  output logic [DATA_W-1:0] rspRdata
);

  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(3);

  logic [BUS_W-1:0]  busQ;
  logic [DEV_W-1:0]  devQ;
  logic [FN_W-1:0]   fnQ;
  logic [OFF_W-1:0]  offQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] tgtWord;
  logic [DATA_W-1:0] viewWord;
  logic [BUS_W-1:0]  nextBus;

  assign nextBus = BUS_W'(firstBus + BUS_W'(1));

  // Validity and routing of the incoming request.
  always_comb begin
    if (reqDev != '0)
      inRoute = RT_BAD;
    else if (reqBus == firstBus)
      inRoute = (reqFunc != '0) ? RT_BAD : RT_LOCAL;
    else if (reqBus == nextBus)
      inRoute = RT_TYPE0;
    else
      inRoute = RT_TYPE1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ   <= '0;
      devQ   <= '0;
      fnQ    <= '0;
      offQ   <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      routeQ <= RT_LOCAL;
    end else if (strobe.load) begin
      busQ   <= reqBus;
      devQ   <= reqDev;
      fnQ    <= reqFunc;
      offQ   <= reqOffset;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      routeQ <= inRoute;
    end
  end

  // Retarget words: outbound viewport with region index, then bus/dev/func.
  always_comb begin
    tgtWord = '0;
    tgtWord[BUS_LSB +: BUS_W] = busQ;
    tgtWord[DEV_LSB +: DEV_W] = devQ;
    tgtWord[FN_LSB  +: FN_W]  = fnQ;
    viewWord = '0;
    viewWord[0] = (routeQ == RT_TYPE1);
  end

  assign regAddr   = strobe.selTarget ? TARGET_ADDR : VIEWPORT_ADDR;
  assign regData   = strobe.selTarget ? tgtWord : viewWord;
  assign winSel    = routeQ;
  assign winWrite  = writeQ;
  assign winOffset = offQ & ALIGN_MASK;
  assign winWdata  = wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspError <= 1'b0;
      rspRdata <= '0;
    end else if (strobe.capture) begin
      rspError <= 1'b0;
      rspRdata <= writeQ ? '0 : winRdata;
    end else if (strobe.reject) begin
      rspError <= 1'b1;
      rspRdata <= writeQ ? '0 : '1;
    end
  end

  // A latched local route always came from a request with device 0, function 0.
  p_local_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (routeQ == RT_LOCAL) |-> (devQ == '0 && fnQ == '0));

endmodule

// File: rtl/cfg_router_ctrl.sv
module cfg_router_ctrl
  import cfg_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  route_e      inRoute,
  input  route_e      routeQ,
  input  logic        regReady,
  input  logic        winReady,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        regValid,
  output logic        winValid,
  output logic        rspValid,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_VIEW, ST_TGT, ST_WIN, ST_REJ, ST_RESP
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    regValid  = 1'b0;
    winValid  = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          if (inRoute == RT_BAD)        stateNext = ST_REJ;
          else if (inRoute == RT_LOCAL) stateNext = ST_WIN;
          else                          stateNext = ST_VIEW;
        end
      end
      ST_VIEW: begin
        regValid = 1'b1;
        if (regReady) stateNext = ST_TGT;
      end
      ST_TGT: begin
        regValid = 1'b1;
        strobe.selTarget = 1'b1;
        if (regReady) stateNext = ST_WIN;
      end
      ST_WIN: begin
        winValid = 1'b1;
        if (winReady) begin
          strobe.capture = 1'b1;
          stateNext = ST_RESP;
        end
      end
      ST_REJ: begin
        strobe.reject = 1'b1;
        stateNext = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // A remote window access starts right after the target write handshake.
  p_win_after_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !$past(winValid) && routeQ != RT_LOCAL)
      |-> $past(regValid && regReady && strobe.selTarget));

endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] VIEWPORT_ADDR = 12'h900,
  parameter logic [REG_AW-1:0] TARGET_ADDR   = 12'h918
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  firstBus,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FN_W-1:0]   reqFunc,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              regValid,
  input  logic              regReady,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              winValid,
  input  logic              winReady,
  output logic [1:0]        winSel,
  output logic              winWrite,
  output logic [OFF_W-1:0]  winOffset,
  output logic [DATA_W-1:0] winWdata,
  input  logic [DATA_W-1:0] winRdata,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspError,
  output logic [DATA_W-1:0] rspRdata
);

  ctrlStrobe_t strobe;
  route_e      inRoute;
  route_e      routeQ;

  cfg_router_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .inRoute  (inRoute),
    .routeQ   (routeQ),
    .regReady (regReady),
    .winReady (winReady),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .regValid (regValid),
    .winValid (winValid),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  cfg_router_dp #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
    .DATA_W(DATA_W), .REG_AW(REG_AW),
    .VIEWPORT_ADDR(VIEWPORT_ADDR), .TARGET_ADDR(TARGET_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .firstBus  (firstBus),
    .reqWrite  (reqWrite),
    .reqBus    (reqBus),
    .reqDev    (reqDev),
    .reqFunc   (reqFunc),
    .reqOffset (reqOffset),
    .reqWdata  (reqWdata),
    .winRdata  (winRdata),
    .inRoute   (inRoute),
    .routeQ    (routeQ),
    .regAddr   (regAddr),
    .regData   (regData),
    .winSel    (winSel),
    .winWrite  (winWrite),
    .winOffset (winOffset),
    .winWdata  (winWdata),
    .rspError  (rspError),
    .rspRdata  (rspRdata)
  );

  p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regReady) |=> (regValid && $stable(regAddr) && $stable(regData)));

  p_win_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !winReady) |=> (winValid && $stable(winSel) && $stable(winOffset)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspRdata) && $stable(rspError)));

  p_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winOffset[1:0] == 2'b00));

endmodule

// File: tb/cfg_router_tb.sv
module cfg_router_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  firstBus = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [11:0] reqOffset = '0;
  logic [31:0] reqWdata = '0;
  logic        regValid;
  logic        regReady = 1'b0;
  logic [11:0] regAddr;
  logic [31:0] regData;
  logic        winValid;
  logic        winReady = 1'b0;
  logic [1:0]  winSel;
  logic        winWrite;
  logic [11:0] winOffset;
  logic [31:0] winWdata;
  logic [31:0] winRdata = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic        rspError;
  logic [31:0] rspRdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  cfg_router u_dut (
    .clk(clk), .rstN(rstN), .firstBus(firstBus),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc),
    .reqOffset(reqOffset), .reqWdata(reqWdata),
    .regValid(regValid), .regReady(regReady), .regAddr(regAddr), .regData(regData),
    .winValid(winValid), .winReady(winReady), .winSel(winSel), .winWrite(winWrite),
    .winOffset(winOffset), .winWdata(winWdata), .winRdata(winRdata),
    .rspValid(rspValid), .rspReady(rspReady), .rspError(rspError), .rspRdata(rspRdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Expected route: 0 local, 1 type-0, 2 type-1, 3 rejected.
  function automatic int expRoute(input logic [7:0] bus, input logic [4:0] dev,
                                  input logic [2:0] fn, input logic [7:0] first);
    if (dev != 0) return 3;
    if (bus == first) return (fn != 0) ? 3 : 0;
    if (bus == 8'(first + 8'd1)) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] packTarget(input logic [7:0] bus, input logic [4:0] dev,
                                             input logic [2:0] fn);
    return {bus, dev, fn, 16'h0000};
  endfunction

  function automatic logic [31:0] rdPattern(input logic [11:0] off);
    return 32'hA500_0000 ^ {20'h0, off} ^ 32'h0003_C000;
  endfunction

  task automatic runReq(input logic [7:0] first, input logic [7:0] bus,
                        input logic [4:0] dev, input logic [2:0] fn,
                        input logic [11:0] off, input bit wr,
                        input logic [31:0] wd, input string tag);
    int route;
    int nReg = 0, nWin = 0, nRsp = 0, regAtWin = 0, guard = 0;
    bit accepted = 0, done = 0, regStall = 0, winStall = 0;
    logic [11:0] rAddr [2];
    logic [31:0] rData [2];
    logic [11:0] pAddr = '0, wOff = '0;
    logic [31:0] pData = '0, wWd = '0, rRd = '0;
    logic [1:0]  pSel = '0, wSel = '0;
    logic [11:0] pOff = '0;
    bit wWr = 0, rErr = 0;
    rAddr[0] = '0; rAddr[1] = '0; rData[0] = '0; rData[1] = '0;
    route = expRoute(bus, dev, fn, first);
    @(negedge clk);
    firstBus = first; reqBus = bus; reqDev = dev; reqFunc = fn;
    reqOffset = off; reqWrite = wr; reqWdata = wd; reqValid = 1'b1;
    winRdata = rdPattern(off);
    while (!done && guard < 200) begin
      guard++;
      regReady = ($urandom % 3) != 0;
      winReady = ($urandom % 3) != 0;
      rspReady = ($urandom % 3) != 0;
      if (regStall)
        chk(regValid && regAddr == pAddr && regData == pData, "R8", "stalled reg write moved",
            regData, pData);
      if (winStall)
        chk(winValid && winSel == pSel && winOffset == pOff, "R8", "stalled window moved",
            {20'h0, winOffset}, {20'h0, pOff});
      regStall = regValid && !regReady; pAddr = regAddr; pData = regData;
      winStall = winValid && !winReady; pSel = winSel; pOff = winOffset;
      if (reqValid && reqReady) accepted = 1;
      if (regValid && regReady) begin
        if (nReg < 2) begin rAddr[nReg] = regAddr; rData[nReg] = regData; end
        nReg++;
      end
      if (winValid && winReady) begin
        nWin++; regAtWin = nReg; wSel = winSel; wOff = winOffset;
        wWr = winWrite; wWd = winWdata;
      end
      if (rspValid && rspReady) begin
        nRsp++; rErr = rspError; rRd = rspRdata; done = 1;
      end
      @(negedge clk);
      if (accepted) reqValid = 1'b0;
    end
    regReady = 1'b0; winReady = 1'b0; rspReady = 1'b0;
    chk(done, "R9", {tag, " response seen"}, 32'(done), 1);
    // After the single response the block is idle again, no second response.
    chk(!rspValid && reqReady, "R9", {tag, " single response"}, {30'h0, rspValid, reqReady}, 1);
    if (route == 3) begin
      chk(nReg == 0, wr ? "R3" : (dev != 0 ? "R1" : "R2"), {tag, " reg writes"}, nReg, 0);
      chk(nWin == 0, wr ? "R3" : (dev != 0 ? "R1" : "R2"), {tag, " window accesses"}, nWin, 0);
      chk(rErr == 1'b1, wr ? "R3" : (dev != 0 ? "R1" : "R2"), {tag, " error flag"}, 32'(rErr), 1);
      chk(rRd == (wr ? 32'h0 : 32'hFFFF_FFFF), wr ? "R3" : (dev != 0 ? "R1" : "R2"),
          {tag, " reject data"}, rRd, wr ? 32'h0 : 32'hFFFF_FFFF);
    end else begin
      chk(rErr == 1'b0, "R9", {tag, " error flag"}, 32'(rErr), 0);
      chk(rRd == (wr ? 32'h0 : rdPattern(off)), "R9", {tag, " response data"}, rRd,
          wr ? 32'h0 : rdPattern(off));
      chk(nWin == 1, "R4", {tag, " window count"}, nWin, 1);
      chk(wSel == 2'(route), route == 0 ? "R4" : (route == 1 ? "R5" : "R6"),
          {tag, " window select"}, {30'h0, wSel}, route);
      chk(wOff == (off & 12'hFFC), "R4", {tag, " window offset"}, {20'h0, wOff},
          {20'h0, off & 12'hFFC});
      chk(wWr == wr && (!wr || wWd == wd), "R9", {tag, " window write data"}, wWd, wr ? wd : wWd);
      if (route == 0) begin
        chk(nReg == 0, "R4", {tag, " no reg write for local"}, nReg, 0);
      end else begin
        chk(nReg == 2, "R7", {tag, " reg write count"}, nReg, 2);
        chk(regAtWin == 2, "R7", {tag, " writes before window"}, regAtWin, 2);
        chk(rAddr[0] == 12'h900 && rData[0] == ((route == 2) ? 32'h1 : 32'h0),
            route == 1 ? "R5" : "R6", {tag, " viewport write"}, rData[0],
            (route == 2) ? 32'h1 : 32'h0);
        chk(rAddr[1] == 12'h918 && rData[1] == packTarget(bus, dev, fn),
            route == 1 ? "R5" : "R6", {tag, " target write"}, rData[1], packTarget(bus, dev, fn));
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !regValid && !winValid && !rspValid, "R9", "reset idle",
        {28'h0, reqReady, regValid, winValid, rspValid}, 32'h8);

    runReq(8'h10, 8'h10, 5'd0, 3'd0, 12'h010, 1'b0, 32'h0,        "root read");
    runReq(8'h10, 8'h10, 5'd0, 3'd3, 12'h004, 1'b0, 32'h0,        "root func3 read");
    runReq(8'h10, 8'h11, 5'd0, 3'd2, 12'h100, 1'b0, 32'h0,        "next bus func2");
    runReq(8'h10, 8'h20, 5'd0, 3'd5, 12'h208, 1'b1, 32'hDEADBEEF, "far bus write");
    runReq(8'h10, 8'h05, 5'd0, 3'd0, 12'h00C, 1'b0, 32'h0,        "lower bus read");
    runReq(8'h10, 8'h11, 5'd1, 3'd0, 12'h000, 1'b0, 32'h0,        "dev1 read");
    runReq(8'h10, 8'h10, 5'd7, 3'd0, 12'h000, 1'b1, 32'h12345678, "dev7 write");
    runReq(8'hFF, 8'h00, 5'd0, 3'd1, 12'h040, 1'b0, 32'h0,        "wrap next bus");
    runReq(8'hFF, 8'hFF, 5'd0, 3'd0, 12'h3FF, 1'b1, 32'hCAFEF00D, "unaligned root write");
    runReq(8'h00, 8'h00, 5'd0, 3'd0, 12'hFFF, 1'b0, 32'h0,        "top offset read");

    for (int i = 0; i < 300; i++) begin
      logic [7:0] f;
      logic [7:0] b;
      logic [4:0] d;
      f = 8'($urandom);
      b = 8'(f + 8'($urandom % 4) - 8'd1);
      d = (($urandom % 5) == 0) ? 5'($urandom) : 5'd0;
      runReq(f, b, d, 3'($urandom), 12'($urandom), 1'($urandom), $urandom, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule